// File: doc/BRIEF.md
# Frame CRC-32 Appender

This block sits in a byte-serial frame path. Upstream hands it a frame one byte per handshake, with the final byte marked. Every payload byte goes straight through to the downstream port in the same cycle. Once the marked byte has been accepted, the block holds the upstream side off and sends four checksum bytes, most significant first. The last of these carries the downstream end marker. The checksum is a 32-bit CRC over every payload byte in order. It uses generator 0x04C11DB7, starts from zero, reflects neither input nor output, and applies no final inversion.

When a frame's last checksum byte leaves, a side channel reports the full frame length in bytes, checksum included. It also raises a flag when the payload length is not a whole number of 32-bit words. For error-path testing, a control input can fold one extra byte of value 0x42 into the checksum of a chosen frame. The frame is selected by its index counted since reset. That frame then carries a deliberately wrong checksum.

Top module: `frame_crc_appender`

## Requirements
- R1: During reset and in the first cycle after it, `m_valid` and `len_valid` are low, and `s_ready` equals `m_ready`.
- R2: Payload bytes appear on `m_data` unchanged, in the same cycle as they are offered. While payload is flowing, `m_valid` follows `s_valid`, `s_ready` follows `m_ready`, and `m_last` stays low.
- R3: After the byte offered with `s_last` has been accepted, four checksum bytes follow, bits 31:24 first. The CRC has polynomial 0x04C11DB7, start value 0, no bit reflection and no final XOR. A one-byte frame 0x01 yields 04 C1 1D B7, and a one-byte frame 0x00 yields 00 00 00 00.
- R4: `m_last` is high only with the fourth checksum byte of a frame.
- R5: `s_ready` is low while checksum bytes are pending, so a byte offered in that time waits and does not reach `m_data`.
- R6: In the cycle after the fourth checksum byte is accepted, `len_valid` is high for exactly one cycle, and `len_bytes` equals the payload byte count plus 4.
- R7: `misalign` is high together with `len_valid` exactly when the payload byte count is not a multiple of 4. It is low whenever `len_valid` is low.
- R8: Each frame's checksum starts from zero, so equal payloads give equal checksums unless R9 applies.
- R9: Frames are indexed from 0 after reset, modulo 2^IDX_W. When `corrupt_en` is high and the current index equals `corrupt_idx`, the byte 0x42 is folded into the CRC after the last payload byte. The frame length is unaffected.
- R10: While `m_ready` is low during the checksum bytes, `m_data` and `m_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Upstream byte valid |
| s_ready | output | 1 | Upstream byte accepted when high with s_valid |
| s_data | input | 8 | Upstream payload byte |
| s_last | input | 1 | Marks the final payload byte of a frame |
| m_valid | output | 1 | Downstream byte valid |
| m_ready | input | 1 | Downstream can take a byte |
| m_data | output | 8 | Downstream byte (payload or checksum) |
| m_last | output | 1 | Marks the final checksum byte |
| len_valid | output | 1 | One-cycle pulse carrying the frame report |
| len_bytes | output | LEN_W | Frame length in bytes including the checksum |
| misalign | output | 1 | Payload length not a multiple of 4 (with len_valid) |
| corrupt_en | input | 1 | Enables checksum corruption of one frame index |
| corrupt_idx | input | IDX_W | Frame index to corrupt |

## Verification
Payload bytes are due on `m_data` in the same cycle they are offered. The first checksum byte is due in the cycle after the last payload byte is accepted, and each further checksum byte follows one downstream handshake later. The length report is due one cycle after the final checksum handshake. The bench keeps that timing by sampling every handshake a quarter period before the rising edge. At each sample the monitor pops the next expected byte or report from the queues the driver filled, so a byte arriving early, late or twice shows as a mismatch or an unexpected item. The downstream stall pattern runs in some frames, so the same ordering is checked with checksum bytes held over several cycles.

// File: rtl/frame_crc_pkg.sv
// Shared constants, types and the byte-serial CRC step for the frame
// checksum appender. Assumes MSB-first, non-reflected CRC arithmetic.
package frame_crc_pkg;

    localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
    localparam logic [7:0]  INJECT_BYTE = 8'h42;
    localparam int          TRAILER_LEN = 4;

    typedef enum logic {
        ST_PAYLOAD = 1'b0,
        ST_TRAILER = 1'b1
    } emit_state_t;

    // Advance a 32-bit CRC by one byte, most significant bit first.
    function automatic logic [31:0] crc_byte_step(input logic [31:0] cur, input logic [7:0] b);
        logic [31:0] r;
        r = cur ^ {b, 24'h0};
        for (int i = 0; i < 8; i++) begin
            r = r[31] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fca_crc_engine.sv
// CRC register for one frame. Folds each accepted payload byte in; on the
// last byte of a marked frame it also folds in the injection byte. Cleared
// when a frame completes. Assumes clear and byte_fire are never both high.
module fca_crc_engine
    import frame_crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_fire,
    input  logic [7:0]  byte_in,
    input  logic        last_byte,
    input  logic        inject,
    input  logic        clear,
    output logic [31:0] crc_q
);

    logic [31:0] step_one;
    logic [31:0] step_two;

    // Compute the plain and the injected next CRC values.
    always_comb begin
        step_one = crc_byte_step(crc_q, byte_in);
        step_two = crc_byte_step(step_one, INJECT_BYTE);
    end

    // Hold the running CRC; zero at reset and after each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clear) begin
            crc_q <= '0;
        end else if (byte_fire) begin
            crc_q <= (last_byte && inject) ? step_two : step_one;
        end
    end

    AST_CRC_FRESH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == 32'h0)) else $error("crc not cleared"); // R8

    AST_NO_CLEAR_DURING_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !byte_fire) else $error("clear during byte"); // R5

endmodule

// File: rtl/fca_len_tracker.sv
// Counts payload bytes of the current frame and, at frame completion,
// reports the length with the checksum bytes added plus an alignment flag.
// Assumes LEN_W is wide enough for the longest frame.
module fca_len_tracker
    import frame_crc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_fire,
    input  logic             frame_done,
    output logic             len_valid,
    output logic [LEN_W-1:0] len_bytes,
    output logic             misalign
);

    localparam logic [LEN_W-1:0] TRAILER_BYTES = LEN_W'(TRAILER_LEN);

    logic [LEN_W-1:0] pay_cnt;

    // Count accepted payload bytes; restart at each frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_cnt <= '0;
        end else if (frame_done) begin
            pay_cnt <= '0;
        end else if (byte_fire) begin
            pay_cnt <= pay_cnt + 1'b1;
        end
    end

    // Produce the one-cycle length report and alignment flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_valid <= 1'b0;
            len_bytes <= '0;
            misalign  <= 1'b0;
        end else if (frame_done) begin
            len_valid <= 1'b1;
            len_bytes <= pay_cnt + TRAILER_BYTES;
            misalign  <= |pay_cnt[1:0];
        end else begin
            len_valid <= 1'b0;
            misalign  <= 1'b0;
        end
    end

    AST_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |-> (len_bytes > TRAILER_BYTES)) else $error("length too small"); // R6

    AST_LEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |=> !len_valid) else $error("length pulse too long"); // R6

    AST_MISALIGN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> len_valid) else $error("misalign without report"); // R7

endmodule

// File: rtl/fca_emit_ctrl.sv
// Sequencer: passes payload handshakes through, then walks four checksum
// byte slots while holding upstream off, and keeps the frame index used
// to select a frame for checksum corruption.
module fca_emit_ctrl
    import frame_crc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic             s_last,
    input  logic             m_ready,
    input  logic             corrupt_en,
    input  logic [IDX_W-1:0] corrupt_idx,
    output logic             s_ready,
    output logic             in_trailer,
    output logic [1:0]       tr_idx,
    output logic             byte_fire,
    output logic             frame_done,
    output logic             inject
);

    localparam logic [1:0] LAST_SLOT = 2'(TRAILER_LEN - 1);

    emit_state_t      state;
    logic [IDX_W-1:0] frame_idx;

    // Decode handshakes and frame completion from the current state.
    always_comb begin
        in_trailer = (state == ST_TRAILER);
        s_ready    = !in_trailer && m_ready;
        byte_fire  = s_valid && s_ready;
        frame_done = in_trailer && m_ready && (tr_idx == LAST_SLOT);
        inject     = corrupt_en && (frame_idx == corrupt_idx);
    end

    // Move between payload and checksum phases and step the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_PAYLOAD;
            tr_idx <= '0;
        end else if (!in_trailer) begin
            if (byte_fire && s_last) begin
                state  <= ST_TRAILER;
                tr_idx <= '0;
            end
        end else if (m_ready) begin
            tr_idx <= tr_idx + 1'b1;
            if (tr_idx == LAST_SLOT) begin
                state <= ST_PAYLOAD;
            end
        end
    end

    // Count completed frames to select the one to corrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_idx <= '0;
        end else if (frame_done) begin
            frame_idx <= frame_idx + 1'b1;
        end
    end

    AST_TRAILER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_trailer && !m_ready) |=> (in_trailer && $stable(tr_idx))) else $error("slot moved under stall"); // R10

    AST_TRAILER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_fire && s_last) |=> (in_trailer && tr_idx == 2'd0)) else $error("no trailer after last"); // R3

endmodule

// File: rtl/frame_crc_appender.sv
// Top: byte-stream frame pass-through that appends a big-endian CRC-32
// (poly 0x04C11DB7, zero start, no reflection, no final XOR) and reports
// the frame length and word alignment. Assumes every frame has at least
// one payload byte and that upstream holds a byte stable until accepted.
module frame_crc_appender
    import frame_crc_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    input  logic             s_last,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [7:0]       m_data,
    output logic             m_last,
    output logic             len_valid,
    output logic [LEN_W-1:0] len_bytes,
    output logic             misalign,
    input  logic             corrupt_en,
    input  logic [IDX_W-1:0] corrupt_idx
);

    logic        in_trailer;
    logic [1:0]  tr_idx;
    logic        byte_fire;
    logic        frame_done;
    logic        inject;
    logic [31:0] crc_q;
    logic [7:0]  crc_byte;

    fca_emit_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_last     (s_last),
        .m_ready    (m_ready),
        .corrupt_en (corrupt_en),
        .corrupt_idx(corrupt_idx),
        .s_ready    (s_ready),
        .in_trailer (in_trailer),
        .tr_idx     (tr_idx),
        .byte_fire  (byte_fire),
        .frame_done (frame_done),
        .inject     (inject)
    );

    fca_crc_engine u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_fire (byte_fire),
        .byte_in   (s_data),
        .last_byte (s_last),
        .inject    (inject),
        .clear     (frame_done),
        .crc_q     (crc_q)
    );

    fca_len_tracker #(.LEN_W(LEN_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_fire  (byte_fire),
        .frame_done (frame_done),
        .len_valid  (len_valid),
        .len_bytes  (len_bytes),
        .misalign   (misalign)
    );

    // Pick the checksum byte for the current slot, high byte first.
    always_comb begin
        case (tr_idx)
            2'd0:    crc_byte = crc_q[31:24];
            2'd1:    crc_byte = crc_q[23:16];
            2'd2:    crc_byte = crc_q[15:8];
            default: crc_byte = crc_q[7:0];
        endcase
    end

    // Steer payload or checksum onto the downstream port.
    always_comb begin
        m_valid = in_trailer ? 1'b1 : s_valid;
        m_data  = in_trailer ? crc_byte : s_data;
        m_last  = in_trailer && (tr_idx == 2'd3);
    end

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid) else $error("last without valid"); // R4

    AST_REPORT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |-> $past(m_valid && m_ready && m_last)) else $error("report not after last"); // R6

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !s_ready && m_last) |=> ($stable(m_data) && m_last)) else $error("final byte moved"); // R10

    AST_NO_INPUT_IN_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !s_valid) |-> !s_ready) else $error("ready while trailing"); // R5

endmodule

// File: tb/frame_crc_appender_tb.sv
// Scoreboard bench: the driver queues expected bytes and reports, the
// monitor pops and compares them at every downstream handshake.
module frame_crc_appender_tb;

    localparam int LEN_W = 16;
    localparam int IDX_W = 4;

    typedef struct {
        logic [7:0] d;
        logic       l;
        int         rq;
    } exp_byte_t;

    typedef struct {
        int len;
        bit mis;
    } exp_len_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [7:0]       s_data = 8'h0;
    logic             s_last = 1'b0;
    logic             m_valid;
    logic             m_ready = 1'b1;
    logic [7:0]       m_data;
    logic             m_last;
    logic             len_valid;
    logic [LEN_W-1:0] len_bytes;
    logic             misalign;
    logic             corrupt_en = 1'b0;
    logic [IDX_W-1:0] corrupt_idx = '0;

    exp_byte_t exp_q[$];
    exp_len_t  len_q[$];
    int        total = 0;
    int        bad = 0;
    int        fidx = 0;
    int        cyc = 0;
    bit        bp = 1'b0;
    bit        mon_on = 1'b0;

    frame_crc_appender #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .len_valid(len_valid), .len_bytes(len_bytes), .misalign(misalign),
        .corrupt_en(corrupt_en), .corrupt_idx(corrupt_idx)
    );

    always #10 clk = ~clk;

    // Downstream stall pattern, changed only at falling edges (R10).
    always @(negedge clk) begin
        cyc++;
        m_ready = bp ? (cyc[0] ^ cyc[2]) : 1'b1;
    end

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {b, 24'h0};
        for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    task automatic check(input bit ok, input int rq, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // Driver: queue expectations, then offer bytes with handshakes.
    task automatic send_frame(input logic [7:0] pl[$]);
        logic [31:0] crc = 32'h0;
        bit          inj;
        int          n = pl.size();
        inj = corrupt_en && (fidx[IDX_W-1:0] == corrupt_idx);
        foreach (pl[i]) begin
            crc = ref_step(crc, pl[i]);
            exp_q.push_back('{pl[i], 1'b0, 2}); // R2 payload unchanged
        end
        if (inj) crc = ref_step(crc, 8'h42); // R9 injected byte
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back('{crc[31-8*k -: 8], (k == 3), inj ? 9 : 3}); // R3 R4 R8
        end
        len_q.push_back('{n + 4, (n % 4) != 0}); // R6 R7
        fidx++;
        foreach (pl[i]) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = pl[i];
            s_last  = (i == n - 1);
            forever begin
                #5;
                if (s_ready) begin
                    @(posedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        // R5: offer junk while the checksum is pending; it must be held off.
        @(negedge clk);
        s_data = 8'hA5;
        s_last = 1'b0;
        #5;
        check(s_ready == 1'b0, 5, "s_ready during checksum", s_ready, 0);
        s_valid = 1'b0;
    endtask

    // Monitor: compare each downstream handshake and each length report.
    always @(negedge clk) begin
        #5;
        if (mon_on) begin
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, 2, "unexpected byte", m_data, 0);
                end else begin
                    exp_byte_t e;
                    e = exp_q.pop_front();
                    check(m_data == e.d, e.rq, "m_data", m_data, e.d);
                    check(m_last == e.l, 4, "m_last", m_last, e.l); // R4
                end
            end
            if (len_valid) begin
                if (len_q.size() == 0) begin
                    check(1'b0, 6, "unexpected report", len_bytes, 0);
                end else begin
                    exp_len_t r;
                    r = len_q.pop_front();
                    check(int'(len_bytes) == r.len, 6, "len_bytes", len_bytes, r.len); // R6
                    check(misalign == r.mis, 7, "misalign", misalign, r.mis);          // R7
                end
            end else begin
                check(misalign == 1'b0, 7, "misalign idle", misalign, 0); // R7
            end
        end
    end

    task automatic run_tests();
        logic [7:0] f[$];
        // R1: reset state
        repeat (3) @(negedge clk);
        #5;
        check(m_valid == 1'b0 && len_valid == 1'b0, 1, "outputs in reset", {m_valid, len_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check(m_valid == 1'b0 && len_valid == 1'b0, 1, "outputs after reset", {m_valid, len_valid}, 0);
        check(s_ready == m_ready, 1, "s_ready after reset", s_ready, m_ready);
        mon_on = 1'b1;
        corrupt_en  = 1'b1;
        corrupt_idx = 4'd1;
        // R3: single byte 0x01 gives 04 C1 1D B7, length 5, misaligned
        f = '{8'h01};
        send_frame(f);
        // R9: second frame (index 1) corrupted
        f = '{8'h00, 8'h11, 8'h22, 8'h33};
        send_frame(f);
        // R8: same payload again, fresh checksum
        send_frame(f);
        // R10: stalls downstream during these frames
        bp = 1'b1;
        f = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h12, 8'h34};
        send_frame(f);
        f = '{};
        for (int i = 0; i < 12; i++) f.push_back(8'(i * 37 + 5));
        send_frame(f);
        bp = 1'b0;
        // R3: zero byte gives a zero checksum
        f = '{8'h00};
        send_frame(f);
        // R9: index matches but corruption disabled
        corrupt_en  = 1'b0;
        corrupt_idx = 4'd6;
        f = '{8'h5A, 8'hC3, 8'h0F};
        send_frame(f);
        // R9: enabled on index 7
        corrupt_en  = 1'b1;
        corrupt_idx = 4'd7;
        f = '{8'h5A, 8'hC3, 8'h0F};
        send_frame(f);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && len_q.size() == 0, 6, "items left over", exp_q.size() + len_q.size(), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                #(20 * 100000);
                bad++;
                total++;
                $display("FAIL R1 watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule